// File: doc/BRIEF.md
# Counter Compare Output Controller

This block pairs a free-running event counter with two compare registers and drives two single-bit outputs from them. A host writes it through a single-cycle write port: an address, a data word and a write strobe. Four locations can be written: two compare values, a mode byte that picks which compare matches each output follows, and a control byte with one 4-bit command nibble per output.

Software moves an output with a one-shot command. Setting a nibble's trigger bit applies the action in the nibble's upper three bits. Bits that are consumed by the command then clear themselves. In hardware, each time the counter steps onto a value equal to a selected compare register, the output inverts. This happens only while that channel's toggle-enable bit is held in the control byte. The counter value, the stored control byte and both outputs are visible at the ports.

Top module: `cmp_out_ctl`

## Requirements
- R1: After a synchronous reset, the counter, both compare registers, the mode byte, the control byte and both outputs are 0.
- R2: The counter increments by one on each clock edge where `cnt_en` is high and holds otherwise. From 0xFFFF it wraps to 0x0000.
- R3: A write of the control byte (address 3) with bit 0 set acts on output 0 at that clock edge, using bits 3:1. The value 001 inverts output 0. The value 010 drives it low and clears bit 2. The value 100 drives it high and clears bit 3. Bit 0 is never kept.
- R4: Output 1 follows the same rules from bits 7:4 of the control byte. Bit 4 is the trigger. Bit 5 alone inverts. Bit 6 alone drives low and clears bit 6. Bit 7 alone drives high and clears bit 7. Bit 4 is never kept.
- R5: A triggered command whose action field is not one of 001, 010 or 100 leaves the output unchanged. The trigger bit is still cleared and the other bits of the nibble are kept. A control write with a trigger bit low changes no output.
- R6: A compare match for output 0 occurs on a counting edge where the counter's new value equals compare 0 (address 0). With mode bits 5:4 = 11, a match on compare 1 (address 1) also counts. Mode values 00 and 01 give no match for output 0. The mode byte is at address 2.
- R7: A compare match for output 1 occurs when the counter's new value equals compare 1 and mode bits 7:6 are 00 or 10. With mode bits 7:6 = 11, a match on either compare register counts. With mode bits 7:6 = 01, output 1 never matches.
- R8: A compare match inverts output 0 only if control bit 1 is already stored before that edge. It inverts output 1 only if control bit 5 is already stored. Otherwise the match leaves the output unchanged.
- R9: When a triggered command and a compare match hit the same output at the same edge, the command's result is the output value and the match is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Counter advance enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 compare 0, 1 compare 1, 2 mode, 3 control |
| wr_data | input | CNT_W (16) | Write data; mode and control use bits 7:0 |
| count | output | CNT_W (16) | Current counter value |
| ctl_state | output | 8 | Stored control byte |
| chan_out | output | 2 | Output levels, bit 0 for output 0, bit 1 for output 1 |

## Verification
The hardest case to reach is a collision: a software command arriving at the very edge where the counter steps onto an enabled compare value. To create it, the stimulus parks the counter one below a compare value with toggling enabled. It then raises the count enable and writes a force command in the same cycle, choosing a force level that differs from what the toggle would give. The wrap corner needs the counter to travel the full 16-bit range. A single long counting run, with compare 0 set to zero, carries it across 0xFFFF.

// File: rtl/cmp_out_pkg.sv
package cmp_out_pkg;

    localparam int ADDR_W = 2;
    localparam int NUM_CH = 2;
    localparam int NIB_W  = 4;
    localparam int CTL_W  = NUM_CH * NIB_W;
    localparam int MODE_W = 8;
    localparam int MODE_BASE = 4;   // each channel's 2-bit source field sits at MODE_BASE + 2*ch

    typedef enum logic [ADDR_W-1:0] {
        REG_CMP0 = 2'd0,
        REG_CMP1 = 2'd1,
        REG_MODE = 2'd2,
        REG_CTL  = 2'd3
    } reg_addr_e;

    // One channel's command nibble, msb first
    typedef struct packed {
        logic drive_hi;
        logic drive_lo;
        logic flip;
        logic go;
    } chan_cmd_t;

    typedef struct packed {
        chan_cmd_t cmd;
        logic      level;
    } chan_state_t;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_OWN    = 2'd1,
        SRC_EITHER = 2'd2
    } match_src_e;

    // Result of a control write on one channel's nibble and level
    function automatic chan_state_t apply_cmd(chan_cmd_t wr, logic level);
        chan_state_t r;
        r.cmd   = wr;
        r.level = level;
        if (wr.go) begin
            case ({wr.drive_hi, wr.drive_lo, wr.flip})
                3'b001: r.level = ~level;
                3'b010: begin
                    r.level        = 1'b0;
                    r.cmd.drive_lo = 1'b0;
                end
                3'b100: begin
                    r.level        = 1'b1;
                    r.cmd.drive_hi = 1'b0;
                end
                default: ;
            endcase
            r.cmd.go = 1'b0;
        end
        return r;
    endfunction

    // Channel 1 also treats field 00 as "own compare"
    function automatic match_src_e decode_src(int unsigned ch, logic [1:0] fld);
        match_src_e s;
        case (fld)
            2'b11:   s = SRC_EITHER;
            2'b10:   s = SRC_OWN;
            2'b00:   s = (ch == 1) ? SRC_OWN : SRC_NONE;
            default: s = SRC_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/cmp_event_counter.sv
module cmp_event_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    output logic [CNT_W-1:0] count_q,
    output logic [CNT_W-1:0] next_count
);

    assign next_count = en ? count_q + CNT_W'(1) : count_q;

    always_ff @(posedge clk) begin
        if (rst) count_q <= '0;
        else     count_q <= next_count;
    end

endmodule

// File: rtl/cmp_match_unit.sv
module cmp_match_unit
    import cmp_out_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             step,
    input  logic [CNT_W-1:0] value,
    input  logic [CNT_W-1:0] own_ref,
    input  logic [CNT_W-1:0] other_ref,
    input  match_src_e       src,
    output logic             hit
);

    logic own_eq;
    logic other_eq;

    always_comb begin
        own_eq   = (value == own_ref);
        other_eq = (value == other_ref);
        case (src)
            SRC_OWN:    hit = step && own_eq;
            SRC_EITHER: hit = step && (own_eq || other_eq);
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/cmp_out_channel.sv
module cmp_out_channel
    import cmp_out_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      cmd_wr,
    input  chan_cmd_t cmd_in,
    input  logic      hit,
    output chan_cmd_t cmd_q,
    output logic      level_q
);

    chan_state_t nxt;

    always_comb nxt = apply_cmd(cmd_in, level_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q   <= '0;
            level_q <= 1'b0;
        end else begin
            if (cmd_wr)
                cmd_q <= nxt.cmd;
            // triggered command outranks a same-edge compare toggle
            if (cmd_wr && cmd_in.go)
                level_q <= nxt.level;
            else if (hit && cmd_q.flip)
                level_q <= ~level_q;
        end
    end

endmodule

// File: rtl/cmp_out_ctl.sv
module cmp_out_ctl
    import cmp_out_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  count,
    output logic [CTL_W-1:0]  ctl_state,
    output logic [NUM_CH-1:0] chan_out
);

    logic [CNT_W-1:0]  ref_q [NUM_CH];
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  next_count;
    logic              ctl_wr;

    assign ctl_wr = wr_en && (reg_addr_e'(wr_addr) == REG_CTL);

    cmp_event_counter #(.CNT_W(CNT_W)) i_counter (
        .clk        (clk),
        .rst        (rst),
        .en         (cnt_en),
        .count_q    (count),
        .next_count (next_count)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_CH; i++) ref_q[i] <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_CMP0: ref_q[0] <= wr_data;
                REG_CMP1: ref_q[1] <= wr_data;
                REG_MODE: mode_q   <= wr_data[MODE_W-1:0];
                default:  ;
            endcase
        end
    end

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        match_src_e src;
        logic       hit;
        chan_cmd_t  cmd_q;

        assign src = decode_src(ch, mode_q[MODE_BASE + 2*ch +: 2]);

        cmp_match_unit #(.CNT_W(CNT_W)) i_match (
            .step      (cnt_en),
            .value     (next_count),
            .own_ref   (ref_q[ch]),
            .other_ref (ref_q[NUM_CH-1-ch]),
            .src       (src),
            .hit       (hit)
        );

        cmp_out_channel i_chan (
            .clk     (clk),
            .rst     (rst),
            .cmd_wr  (ctl_wr),
            .cmd_in  (chan_cmd_t'(wr_data[NIB_W*ch +: NIB_W])),
            .hit     (hit),
            .cmd_q   (cmd_q),
            .level_q (chan_out[ch])
        );

        assign ctl_state[NIB_W*ch +: NIB_W] = cmd_q;
    end

endmodule

// File: rtl/cmp_out_ctl_chk.sv
module cmp_out_ctl_chk
    import cmp_out_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              cnt_en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic [CNT_W-1:0]  count,
    input logic [CTL_W-1:0]  ctl_state,
    input logic [NUM_CH-1:0] chan_out
);

    logic ctl_hit;
    logic trig0;
    logic trig1;

    assign ctl_hit = wr_en && (wr_addr == REG_CTL);
    assign trig0   = ctl_hit && wr_data[0];
    assign trig1   = ctl_hit && wr_data[4];

    p_count_step_r2: assert property (@(posedge clk) disable iff (rst)
        cnt_en |=> count == $past(count) + CNT_W'(1));

    p_count_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !cnt_en |=> $stable(count));

    p_force_hi0_r3: assert property (@(posedge clk) disable iff (rst)
        (ctl_hit && wr_data[3:0] == 4'b1001) |=> chan_out[0]);

    p_force_lo1_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl_hit && wr_data[7:4] == 4'b0101) |=> !chan_out[1]);

    p_trig_never_kept_r5: assert property (@(posedge clk) disable iff (rst)
        ctl_hit |=> (!ctl_state[0] && !ctl_state[4]));

    p_idle0_r6: assert property (@(posedge clk) disable iff (rst)
        (!trig0 && !cnt_en) |=> $stable(chan_out[0]));

    p_idle1_r7: assert property (@(posedge clk) disable iff (rst)
        (!trig1 && !cnt_en) |=> $stable(chan_out[1]));

    p_gate0_r8: assert property (@(posedge clk) disable iff (rst)
        (!trig0 && !ctl_state[1]) |=> $stable(chan_out[0]));

    p_gate1_r8: assert property (@(posedge clk) disable iff (rst)
        (!trig1 && !ctl_state[5]) |=> $stable(chan_out[1]));

endmodule

bind cmp_out_ctl cmp_out_ctl_chk #(.CNT_W(CNT_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .count     (count),
    .ctl_state (ctl_state),
    .chan_out  (chan_out)
);

// File: tb/test_cmp_out_ctl.sv
module test_cmp_out_ctl;

    logic        clk = 1'b0;
    logic        rst;
    logic        cnt_en;
    logic        wr_en;
    logic [1:0]  wr_addr;
    logic [15:0] wr_data;
    logic [15:0] count;
    logic [7:0]  ctl_state;
    logic [1:0]  chan_out;

    int    checks = 0;
    int    fails  = 0;
    bit    started = 0;
    bit    done    = 0;
    string phase  = "R1";

    // reference state
    logic [15:0] m_cnt, m_c0, m_c1;
    logic [7:0]  m_mode, m_ctl;
    logic        m_o0, m_o1;

    always #10 clk = ~clk;

    cmp_out_ctl i_cmp_out_ctl (
        .clk       (clk),
        .rst       (rst),
        .cnt_en    (cnt_en),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .count     (count),
        .ctl_state (ctl_state),
        .chan_out  (chan_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin : model
        logic [15:0] nxt;
        logic [7:0]  nv;
        bit          t0, t1, h0, h1;
        if (rst) begin
            m_cnt = 0; m_c0 = 0; m_c1 = 0; m_mode = 0; m_ctl = 0; m_o0 = 0; m_o1 = 0;
        end else begin
            nxt = cnt_en ? m_cnt + 16'd1 : m_cnt;
            h0 = cnt_en && ((m_mode[5:4] == 2'b10 && nxt == m_c0) ||
                            (m_mode[5:4] == 2'b11 && (nxt == m_c0 || nxt == m_c1)));
            h1 = cnt_en && (((m_mode[7:6] == 2'b00 || m_mode[7:6] == 2'b10) && nxt == m_c1) ||
                            (m_mode[7:6] == 2'b11 && (nxt == m_c0 || nxt == m_c1)));
            t0 = h0 && m_ctl[1];
            t1 = h1 && m_ctl[5];
            if (wr_en) begin
                if (wr_addr == 2'd0) m_c0 = wr_data;
                else if (wr_addr == 2'd1) m_c1 = wr_data;
                else if (wr_addr == 2'd2) m_mode = wr_data[7:0];
                else begin
                    nv = wr_data[7:0];
                    if (nv[0]) begin
                        t0 = 0;
                        if (nv[3:1] == 3'b001) m_o0 = ~m_o0;
                        else if (nv[3:1] == 3'b010) begin m_o0 = 0; nv[2] = 0; end
                        else if (nv[3:1] == 3'b100) begin m_o0 = 1; nv[3] = 0; end
                        nv[0] = 0;
                    end
                    if (nv[4]) begin
                        t1 = 0;
                        if (nv[7:5] == 3'b001) m_o1 = ~m_o1;
                        else if (nv[7:5] == 3'b010) begin m_o1 = 0; nv[6] = 0; end
                        else if (nv[7:5] == 3'b100) begin m_o1 = 1; nv[7] = 0; end
                        nv[4] = 0;
                    end
                    m_ctl = nv;
                end
            end
            if (t0) m_o0 = ~m_o0;
            if (t1) m_o1 = ~m_o1;
            m_cnt = nxt;
        end
    end

    // per-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (started && !done)
            chk({phase, " per-cycle"}, {6'd0, chan_out, ctl_state, count},
                {6'd0, m_o1, m_o0, m_ctl, m_cnt});
    end

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n);
        cnt_en = 1'b1;
        repeat (n) @(negedge clk);
        cnt_en = 1'b0;
    endtask

    initial begin
        rst = 1'b1; cnt_en = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        @(posedge clk);
        started = 1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset", {chan_out, ctl_state, count}, 26'd0);

        phase = "R2";
        run(10);
        chk("R2 count", count, 16'd10);

        phase = "R3";
        wr(2'd3, 16'h0003); chk("R3 toggle", {chan_out, ctl_state}, {2'b01, 8'h02});
        wr(2'd3, 16'h0005); chk("R3 low",    {chan_out, ctl_state}, {2'b00, 8'h00});
        wr(2'd3, 16'h0009); chk("R3 high",   {chan_out, ctl_state}, {2'b01, 8'h00});
        wr(2'd3, 16'h0005); chk("R3 low2",   {chan_out, ctl_state}, {2'b00, 8'h00});

        phase = "R4";
        wr(2'd3, 16'h0030); chk("R4 toggle", {chan_out, ctl_state}, {2'b10, 8'h20});
        wr(2'd3, 16'h0050); chk("R4 low",    {chan_out, ctl_state}, {2'b00, 8'h00});
        wr(2'd3, 16'h0090); chk("R4 high",   {chan_out, ctl_state}, {2'b10, 8'h00});

        phase = "R5";
        wr(2'd3, 16'h000F); chk("R5 multi0", {chan_out, ctl_state}, {2'b10, 8'h0E});
        wr(2'd3, 16'h0070); chk("R5 multi1", {chan_out, ctl_state}, {2'b10, 8'h60});
        wr(2'd3, 16'h0004); chk("R5 no trig", {chan_out, ctl_state}, {2'b10, 8'h04});

        phase = "R6";
        wr(2'd0, 16'd15); wr(2'd1, 16'd18); wr(2'd2, 16'h0020); wr(2'd3, 16'h0022);
        run(5);
        chk("R6 cmp0 hit", {chan_out, count}, {2'b11, 16'd15});
        phase = "R7";
        run(3);
        chk("R7 cmp1 hit mode00", {chan_out, count}, {2'b01, 16'd18});
        wr(2'd2, 16'h0040); wr(2'd1, 16'd20);
        run(2);
        chk("R7 mode01 none", {chan_out, count}, {2'b01, 16'd20});
        wr(2'd2, 16'h00C0); wr(2'd0, 16'd22);
        run(2);
        chk("R7 either via cmp0", {chan_out, count}, {2'b11, 16'd22});

        phase = "R6";
        wr(2'd2, 16'h0030); wr(2'd1, 16'd24);
        run(2);
        chk("R6 either via cmp1", {chan_out, count}, {2'b00, 16'd24});

        phase = "R8";
        wr(2'd3, 16'h0000); wr(2'd0, 16'd26);
        run(2);
        chk("R8 gated off", {chan_out, count}, {2'b00, 16'd26});

        phase = "R9";
        wr(2'd3, 16'h0022); wr(2'd0, 16'd30);
        run(3);
        cnt_en = 1'b1; wr_en = 1'b1; wr_addr = 2'd3; wr_data = 16'h0025;
        @(negedge clk);
        cnt_en = 1'b0; wr_en = 1'b0;
        chk("R9 command wins", {chan_out, ctl_state, count}, {2'b00, 8'h20, 16'd30});

        phase = "R2";
        wr(2'd3, 16'h0002); wr(2'd0, 16'd0); wr(2'd2, 16'h0020);
        run(65506);
        chk("R2 wrap count", count, 16'd0);
        chk("R6 wrap match", chan_out, 2'b01);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1;
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule